// File: doc/BRIEF.md
# Inter-Processor Channel Semaphore Register

This block holds the handshake state of a set of message channels shared by a host processor and a coprocessor. Every channel owns a 2-bit field inside one 32-bit word. Neither side ever rewrites the whole word. The host has a small register bus and the coprocessor has its own write port. Each side changes a channel by writing a mask to a set word or a clear word: ones in the mask set or clear the matching bits, and zeros leave them alone. Both sides can therefore move their own channel without a read-modify-write cycle that could race with the other side.

The four field encodings are chosen so that each step of the request/response protocol is a single set or a single clear. A channel that is free (2) gets a request posted by clearing both bits (0). The other side takes the request by setting bit 0 (1). It posts the response by setting both bits (3). The requester acknowledges by clearing bit 0, which returns the channel to free (2). For every channel the block decodes the field into four state flags. It also raises a one-cycle change pulse whenever the field takes a new value, which can drive a doorbell or a receive interrupt.

Top module: `chan_sema_reg`

## Requirements
- R1: After reset every field is 0, so every channel reads "request signaled" (chReqSig all ones) and no change pulse is raised.
- R2: A host read (hostSel=1, hostWr=0) at byte offset 0x0, 0x4 or 0x8 returns the status word on hostRdata in the same cycle. A read at any other offset, including an unaligned one, returns 0.
- R3: A host write to offset 0x4 sets every status bit whose wdata bit is 1. The new value is visible from the next cycle.
- R4: A host write to offset 0x8 clears every status bit whose wdata bit is 1. The new value is visible from the next cycle.
- R5: Writes to offset 0x0, to 0xC, or to any offset with address bits [1:0] not equal to 0 leave the status unchanged.
- R6: The coprocessor port (copWe, copAddr, copWdata) uses the same offsets and set/clear rules as the host bus.
- R7: When a set and a clear of the same bit arrive in the same cycle, one from each port, the bit ends up 1.
- R8: Channel n uses status bits [2n+1:2n]. Value 0 raises chReqSig[n], 1 raises chReqQued[n], 2 raises chFree[n], and 3 raises chRspRdy[n]. The protocol sequence free(2) → clear 0b11 → 0 → set 0b01 → 1 → set 0b11 → 3 → clear 0b01 → 2 follows these encodings.
- R9: chChange[n] is high for exactly one cycle, the cycle after a write edge that changed field n. It stays low when a write leaves the field unchanged.
- R10: Status bits at and above 2*NUM_CH always read as 0 and ignore writes.
- R11: A write that touches only one channel's bits leaves every other channel's field and change pulse unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host bus access this cycle |
| hostWr | input | 1 | Host access is a write (1) or a read (0) |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWdata | input | 32 | Host write mask |
| hostRdata | output | 32 | Host read data, combinational |
| copWe | input | 1 | Coprocessor write strobe |
| copAddr | input | ADDR_W | Coprocessor byte offset |
| copWdata | input | 32 | Coprocessor write mask |
| chState | output | 2*NUM_CH | All channel fields, channel n at [2n+1:2n] |
| chReqSig | output | NUM_CH | Field equals 0 |
| chReqQued | output | NUM_CH | Field equals 1 |
| chFree | output | NUM_CH | Field equals 2 |
| chRspRdy | output | NUM_CH | Field equals 3 |
| chChange | output | NUM_CH | One-cycle pulse after a field changes |

## Verification
The two updates that can meet in one cycle are a host write and a coprocessor write. They may hit the same bits with opposite intent, or hit different channels. The bench drives both ports in the same cycle with overlapping set and clear masks, in both directions: host clears while the coprocessor sets, and host sets while the coprocessor clears. It then checks that every contested bit is 1 and that every uncontested bit follows its own write. A pseudo-random stretch of cycles puts writes on both ports at once together with host reads. Each cycle is judged against a model of the set-over-clear rule that also predicts the change pulses.

// File: rtl/chan_sema_pkg.sv
package chan_sema_pkg;

  localparam int SEM_WORD_W = 32;
  localparam int SEM_FIELD_W = 2;
  localparam int SEM_MAX_CH = SEM_WORD_W / SEM_FIELD_W;

  // word index (byte offset >> 2) of each register view
  localparam int SEM_IDX_STATUS = 0;
  localparam int SEM_IDX_SET = 1;
  localparam int SEM_IDX_CLR = 2;

  typedef enum logic [1:0] {
    CS_REQ_SIGNALED = 2'd0,
    CS_REQ_QUEUED = 2'd1,
    CS_FREE = 2'd2,
    CS_RSP_READY = 2'd3
  } chanState_e;

  // strobes handed from the decoder to the state datapath
  typedef struct packed {
    logic [SEM_WORD_W-1:0] setMask;
    logic [SEM_WORD_W-1:0] clrMask;
    logic rdEn;
  } semaStrobe_t;

endpackage

// File: rtl/chan_sema_ctrl.sv
module chan_sema_ctrl
  import chan_sema_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  input  logic              copWe,
  input  logic [ADDR_W-1:0] copAddr,
  input  logic [31:0]       copWdata,
  output semaStrobe_t       strb
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int USED_W = SEM_FIELD_W * NUM_CH;
  localparam logic [SEM_WORD_W-1:0] VALID =
    (USED_W >= SEM_WORD_W) ? {SEM_WORD_W{1'b1}} : ((32'd1 << USED_W) - 32'd1);

  // aligned word hit on one register index
  function automatic logic wordHit(input logic [ADDR_W-1:0] a, input int idx);
    return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] == IDX_W'(idx));
  endfunction

  logic hostAct;
  logic hostSetHit;
  logic hostClrHit;
  logic copSetHit;
  logic copClrHit;
  logic hostRdHit;
  logic [SEM_WORD_W-1:0] rawSet;
  logic [SEM_WORD_W-1:0] rawClr;

  always_comb begin
    hostAct = hostSel & hostWr;
    hostSetHit = hostAct & wordHit(hostAddr, SEM_IDX_SET);
    hostClrHit = hostAct & wordHit(hostAddr, SEM_IDX_CLR);
    copSetHit = copWe & wordHit(copAddr, SEM_IDX_SET);
    copClrHit = copWe & wordHit(copAddr, SEM_IDX_CLR);
    hostRdHit = hostSel & ~hostWr &
                (wordHit(hostAddr, SEM_IDX_STATUS) |
                 wordHit(hostAddr, SEM_IDX_SET) |
                 wordHit(hostAddr, SEM_IDX_CLR));
  end

  // merge the two ports; fields beyond the configured count never see a strobe
  always_comb begin
    rawSet = ({SEM_WORD_W{hostSetHit}} & hostWdata) |
             ({SEM_WORD_W{copSetHit}} & copWdata);
    rawClr = ({SEM_WORD_W{hostClrHit}} & hostWdata) |
             ({SEM_WORD_W{copClrHit}} & copWdata);
    strb.setMask = rawSet & VALID;
    strb.clrMask = rawClr & VALID;
    strb.rdEn = hostRdHit;
  end

endmodule

// File: rtl/chan_sema_dp.sv
module chan_sema_dp
  import chan_sema_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  semaStrobe_t              strb,
  output logic [31:0]              rdData,
  output logic [SEM_FIELD_W*NUM_CH-1:0] fields,
  output logic [NUM_CH-1:0]        isReqSig,
  output logic [NUM_CH-1:0]        isReqQued,
  output logic [NUM_CH-1:0]        isFree,
  output logic [NUM_CH-1:0]        isRspRdy,
  output logic [NUM_CH-1:0]        changed
);

  localparam int USED_W = SEM_FIELD_W * NUM_CH;

  logic [SEM_WORD_W-1:0] stateQ;
  logic [SEM_WORD_W-1:0] stateNext;
  logic [NUM_CH-1:0] diffNext;
  logic [NUM_CH-1:0] changeQ;

  // set wins over clear on the same bit
  always_comb begin
    stateNext = (stateQ & ~strb.clrMask) | strb.setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      changeQ <= '0;
    end else begin
      stateQ <= stateNext;
      changeQ <= diffNext;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
    chanState_e fld;
    assign fld = chanState_e'(stateQ[SEM_FIELD_W*n +: SEM_FIELD_W]);
    assign diffNext[n] = stateNext[SEM_FIELD_W*n +: SEM_FIELD_W] !=
                         stateQ[SEM_FIELD_W*n +: SEM_FIELD_W];
    assign isReqSig[n] = (fld == CS_REQ_SIGNALED);
    assign isReqQued[n] = (fld == CS_REQ_QUEUED);
    assign isFree[n] = (fld == CS_FREE);
    assign isRspRdy[n] = (fld == CS_RSP_READY);
  end

  assign fields = stateQ[USED_W-1:0];
  assign changed = changeQ;
  assign rdData = strb.rdEn ? stateQ : 32'd0;

endmodule

// File: rtl/chan_sema_reg.sv
module chan_sema_reg
  import chan_sema_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [31:0]           hostWdata,
  output logic [31:0]           hostRdata,
  input  logic                  copWe,
  input  logic [ADDR_W-1:0]     copAddr,
  input  logic [31:0]           copWdata,
  output logic [2*NUM_CH-1:0]   chState,
  output logic [NUM_CH-1:0]     chReqSig,
  output logic [NUM_CH-1:0]     chReqQued,
  output logic [NUM_CH-1:0]     chFree,
  output logic [NUM_CH-1:0]     chRspRdy,
  output logic [NUM_CH-1:0]     chChange
);

  semaStrobe_t strb;

  chan_sema_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .hostSel  (hostSel),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .copWe    (copWe),
    .copAddr  (copAddr),
    .copWdata (copWdata),
    .strb     (strb)
  );

  chan_sema_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdData   (hostRdata),
    .fields   (chState),
    .isReqSig (chReqSig),
    .isReqQued(chReqQued),
    .isFree   (chFree),
    .isRspRdy (chRspRdy),
    .changed  (chChange)
  );

endmodule

// File: rtl/chan_sema_chk.sv
module chan_sema_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                hostSel,
  input logic                hostWr,
  input logic [ADDR_W-1:0]   hostAddr,
  input logic [31:0]         hostWdata,
  input logic [31:0]         hostRdata,
  input logic                copWe,
  input logic [ADDR_W-1:0]   copAddr,
  input logic [31:0]         copWdata,
  input logic [2*NUM_CH-1:0] chState,
  input logic [NUM_CH-1:0]   chReqSig,
  input logic [NUM_CH-1:0]   chReqQued,
  input logic [NUM_CH-1:0]   chFree,
  input logic [NUM_CH-1:0]   chRspRdy,
  input logic [NUM_CH-1:0]   chChange
);

  localparam int USED_W = 2 * NUM_CH;
  localparam logic [31:0] VALID =
    (USED_W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << USED_W) - 32'd1);

  logic [31:0] stWide;
  logic [31:0] anySet;
  logic [31:0] anyClr;
  logic [31:0] pureClr;

  assign stWide = 32'(chState);
  assign anySet = (((hostSel && hostWr && hostAddr == ADDR_W'(4)) ? hostWdata : 32'd0) |
                   ((copWe && copAddr == ADDR_W'(4)) ? copWdata : 32'd0)) & VALID;
  assign anyClr = (((hostSel && hostWr && hostAddr == ADDR_W'(8)) ? hostWdata : 32'd0) |
                   ((copWe && copAddr == ADDR_W'(8)) ? copWdata : 32'd0)) & VALID;
  assign pureClr = anyClr & ~anySet;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (anySet != 0) |=> ((stWide & $past(anySet)) == $past(anySet))); // R7

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (pureClr != 0) |=> ((stWide & $past(pureClr)) == 32'd0)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (anySet == 0 && anyClr == 0) |=> $stable(chState)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((hostRdata & ~VALID) == 32'd0)); // R10

  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $stable(chState) |-> (chChange == '0)); // R9

  for (genvar n = 0; n < NUM_CH; n++) begin : g_dec
    AST_DECODE_ONE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot({chReqSig[n], chReqQued[n], chFree[n], chRspRdy[n]})); // R8
  end

endmodule

bind chan_sema_reg chan_sema_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostSel  (hostSel),
  .hostWr   (hostWr),
  .hostAddr (hostAddr),
  .hostWdata(hostWdata),
  .hostRdata(hostRdata),
  .copWe    (copWe),
  .copAddr  (copAddr),
  .copWdata (copWdata),
  .chState  (chState),
  .chReqSig (chReqSig),
  .chReqQued(chReqQued),
  .chFree   (chFree),
  .chRspRdy (chRspRdy),
  .chChange (chChange)
);

// File: tb/test_chan_sema_reg.sv
`timescale 1ns/1ps
module test_chan_sema_reg;

  localparam int NCH = 4;
  localparam int AW = 4;
  localparam logic [31:0] VALID = 32'h0000_00FF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0;
  logic hostWr = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic copWe = 1'b0;
  logic [AW-1:0] copAddr = '0;
  logic [31:0] copWdata = '0;
  logic [2*NCH-1:0] chState;
  logic [NCH-1:0] chReqSig, chReqQued, chFree, chRspRdy, chChange;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  chan_sema_reg #(.NUM_CH(NCH), .ADDR_W(AW)) i_chan_sema_reg (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata),
    .copWe(copWe), .copAddr(copAddr), .copWdata(copWdata),
    .chState(chState), .chReqSig(chReqSig), .chReqQued(chReqQued),
    .chFree(chFree), .chRspRdy(chRspRdy), .chChange(chChange)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [31:0] st;
    logic [NCH-1:0] chg;
    logic rdChk;
    logic [31:0] rd;
  } exp_t;

  exp_t expQ[$];
  string tagQ[$];
  logic [31:0] model = '0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle on both ports; expected result pushed to the scoreboard
  task automatic cyc(input logic hS, input logic hW, input logic [AW-1:0] hA,
                     input logic [31:0] hD, input logic cW, input logic [AW-1:0] cA,
                     input logic [31:0] cD, input string tag);
    logic [31:0] sets, clrs, nxt;
    exp_t e;
    @(negedge clk);
    hostSel = hS; hostWr = hW; hostAddr = hA; hostWdata = hD;
    copWe = cW; copAddr = cA; copWdata = cD;
    sets = ((hS && hW && hA == 4'h4) ? hD : 32'd0) | ((cW && cA == 4'h4) ? cD : 32'd0);
    clrs = ((hS && hW && hA == 4'h8) ? hD : 32'd0) | ((cW && cA == 4'h8) ? cD : 32'd0);
    nxt = ((model & ~clrs) | sets) & VALID;
    e.st = nxt;
    for (int n = 0; n < NCH; n++) e.chg[n] = (nxt[2*n +: 2] != model[2*n +: 2]);
    e.rdChk = hS && !hW;
    e.rd = (hA == 4'h0 || hA == 4'h4 || hA == 4'h8) ? nxt : 32'd0;
    expQ.push_back(e);
    tagQ.push_back(tag);
    model = nxt;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 4'h0, 32'd0, 1'b0, 4'h0, 32'd0, tag);
  endtask

  task automatic hwr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, 1'b0, 4'h0, 32'd0, tag);
  endtask

  task automatic hrd(input logic [AW-1:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'd0, 1'b0, 4'h0, 32'd0, tag);
  endtask

  task automatic cwr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
    cyc(1'b0, 1'b0, 4'h0, 32'd0, 1'b1, a, d, tag);
  endtask

  // monitor: compares just after each edge with the item driven before it
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      string t;
      logic [1:0] f;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, "state", 32'(chState), e.st);
      check({t, " R9"}, "change", 32'(chChange), 32'(e.chg));
      for (int n = 0; n < NCH; n++) begin
        f = e.st[2*n +: 2];
        check("R8", "decode", {28'd0, chReqSig[n], chReqQued[n], chFree[n], chRspRdy[n]},
              {28'd0, f == 2'd0, f == 2'd1, f == 2'd2, f == 2'd3});
      end
      if (e.rdChk) check({t, " R2"}, "rdata", hostRdata, e.rd);
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R1", "reset state", 32'(chState), 32'd0);
    check("R1", "reset change", 32'(chChange), 32'd0);
    check("R1", "reset reqSig", 32'(chReqSig), 32'h0000_000F);

    hrd(4'h0, "R1 R2");
    hwr(4'h4, 32'h0000_00AA, "R3");            // all channels free
    hrd(4'h4, "R2");
    hrd(4'h8, "R2");
    hrd(4'hC, "R2");
    hrd(4'h1, "R2 unaligned");
    // protocol on channel 1 (bits [3:2])
    hwr(4'h8, 32'h0000_000C, "R4 R8 R11");     // post request -> 0
    cwr(4'h4, 32'h0000_0004, "R6 R8");         // take request -> 1
    cwr(4'h4, 32'h0000_000C, "R6 R8");         // post response -> 3
    hwr(4'h8, 32'h0000_0004, "R4 R8");         // acknowledge -> 2
    hwr(4'h4, 32'h0000_00AA, "R9 no change");
    hwr(4'h0, 32'h0000_00FF, "R5 status write");
    hwr(4'hC, 32'h0000_0055, "R5 offset C");
    hwr(4'h6, 32'h0000_00FF, "R5 unaligned");
    cwr(4'h0, 32'h0000_0000, "R5 cop status");
    hwr(4'h4, 32'hFFFF_FF00, "R10 upper set");
    hrd(4'h0, "R10 R2");
    // same-cycle contention between ports
    cyc(1'b1, 1'b1, 4'h8, 32'h0000_0030, 1'b1, 4'h4, 32'h0000_0010, "R7 hclr cset");
    cyc(1'b1, 1'b1, 4'h4, 32'h0000_0001, 1'b1, 4'h8, 32'h0000_0003, "R7 hset cclr");
    cyc(1'b1, 1'b0, 4'h0, 32'd0, 1'b1, 4'h8, 32'h0000_00C0, "R6 R2 read+cop");
    hwr(4'h8, 32'hFFFF_FFFF, "R4 clear all");
    idle("R9 idle");
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[0], lfsr[1], {lfsr[3:2], 2'b00}, {lfsr[7:0], lfsr[31:8]},
          lfsr[4], {lfsr[6:5], 2'b00}, {lfsr[15:0], lfsr[31:16]}, "R6 R7 R11 mixed");
    end
    idle("R9 idle");
    idle("R9 idle");
    while (expQ.size() > 0) @(posedge clk);
    #5;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule